// File: doc/BRIEF.md
# Two-Port Word Memory with Address-Conflict Arbitration

This block is a word-organised memory with two fully independent ports, called left and right. Each port has its own address, write data, read data, write strobe, output enable, a pair of chip selects and two byte-lane enables. Both ports can work in every cycle. Reads are registered and appear one cycle after the request. Every read returns the word as it stood before any write of the same cycle.

When both ports select the same word in one cycle and at least one of them writes, an arbiter picks a winner. The losing port sees its active-low busy output asserted in that same cycle, and its write is dropped. A mode input sets the role of the instance. As the master, the instance computes the busy flags itself. As a slave, its busy outputs stay high, and externally supplied busy inputs block the writes of the flagged ports. Several instances can then sit side by side to form a wider word, with one master deciding for all of them.

The address width sets the depth. The full-size device uses 16 address bits, and the default here is smaller. Two chip selects per port allow depth expansion without an external decoder.

Top module: `dpram_arb`

## Requirements
- R1: During and after reset both read-data outputs are zero and both busy outputs are high until a request changes them.
- R2: A selected read with output enable high returns the stored word one clock later. A read that meets a write to the same word in the same cycle returns the value from before that write.
- R3: A write changes only the enabled byte lanes: upper enable for bits 15:8, lower enable for bits 7:0. The other lane keeps its value.
- R4: On a read, a lane whose enable is low comes back as zero, while an enabled lane carries the stored byte.
- R5: A port is selected only when its chip select 0 is low and its chip select 1 is high. An unselected port writes nothing and returns zero read data.
- R6: A read made with output enable low returns zero on the next cycle.
- R7: Both ports may read the same word in one cycle. Both receive it, and neither busy flag is raised.
- R8: In master mode, a busy flag goes low only in a cycle where both ports are selected, their addresses are equal and at least one of them writes. In that case exactly one flag goes low.
- R9: In master mode, when neither port had selected the conflicting address in the previous cycle, the left port wins. The right port's busy goes low and its write is discarded.
- R10: In master mode, if only the right port was selected at that same address in the previous cycle, the right port wins and the left port's write is discarded. If both or neither held it, the left port wins.
- R11: In slave mode both busy outputs stay high, and a low busy input blocks the write of that port while the other port writes normally.
- R12: In slave mode, when both ports write one word in the same cycle, each lane enabled on the left takes the left data, and a lane enabled only on the right takes the right data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ms_sel | input | 1 | High: master (computes busy). Low: slave (obeys busy inputs) |
| l_addr | input | ADDR_W | Left word address |
| l_wdata | input | 16 | Left write data |
| l_rdata | output | 16 | Left read data, one cycle after the request |
| l_wr | input | 1 | Left write strobe, high writes |
| l_oe | input | 1 | Left output enable |
| l_ce0_n | input | 1 | Left chip select 0, active low |
| l_ce1 | input | 1 | Left chip select 1, active high |
| l_ub | input | 1 | Left upper-lane enable |
| l_lb | input | 1 | Left lower-lane enable |
| l_busy_n_i | input | 1 | Left busy from an external master (slave mode) |
| l_busy_n_o | output | 1 | Left busy, active low, driven in master mode |
| r_addr | input | ADDR_W | Right word address |
| r_wdata | input | 16 | Right write data |
| r_rdata | output | 16 | Right read data, one cycle after the request |
| r_wr | input | 1 | Right write strobe, high writes |
| r_oe | input | 1 | Right output enable |
| r_ce0_n | input | 1 | Right chip select 0, active low |
| r_ce1 | input | 1 | Right chip select 1, active high |
| r_ub | input | 1 | Right upper-lane enable |
| r_lb | input | 1 | Right lower-lane enable |
| r_busy_n_i | input | 1 | Right busy from an external master (slave mode) |
| r_busy_n_o | output | 1 | Right busy, active low, driven in master mode |

## Verification
Every word of a 64-word configuration is first written through one port and read back through the other. Each word uses a distinct computed pattern, so a swapped port, a wrong address or a missing latency stage gives a mismatch. A second sweep writes through every combination of lane enables and reads back with a shifted combination. This separates write masking from read masking and exposes a lane mix-up. Targeted sequences then build each conflict shape: simultaneous new writers, a read against a write, a right port that already held the word, and both ports holding it. Read-back after each one shows which write survived. Slave-mode runs with blocked and unblocked inputs show that the busy outputs stay quiet and that the lanes merge on a shared word.

// File: rtl/dpram_arb_pkg.sv
package dpram_arb_pkg;
    localparam int PORTS = 2;
    localparam int LANES = 2;

    typedef enum logic {
        PORT_L = 1'b0,
        PORT_R = 1'b1
    } port_e;

    function automatic logic [LANES-1:0] lane_pick(input logic upper, input logic lower);
        return {upper, lower};
    endfunction
endpackage

// File: rtl/dpram_port_dec.sv
module dpram_port_dec
    import dpram_arb_pkg::*;
(
    input  logic             ce0_n,
    input  logic             ce1,
    input  logic             wr,
    input  logic             oe,
    input  logic             ub,
    input  logic             lb,
    output logic             sel,
    output logic             wr_req,
    output logic             rd_drive,
    output logic [LANES-1:0] lanes
);
    always_comb begin
        sel      = !ce0_n && ce1;
        wr_req   = sel && wr;
        rd_drive = sel && !wr && oe;
        lanes    = lane_pick(ub, lb);
    end
endmodule

// File: rtl/dpram_arbiter.sv
module dpram_arbiter
    import dpram_arb_pkg::*;
#(
    parameter int ADDR_W = 10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           ms_sel,
    input  logic [PORTS-1:0]               sel,
    input  logic [PORTS-1:0]               wr_req,
    input  logic [PORTS-1:0][ADDR_W-1:0]   addr,
    input  logic [PORTS-1:0]               busy_in_n,
    output logic [PORTS-1:0]               busy_out_n,
    output logic [PORTS-1:0]               wr_ok
);
    typedef struct packed {
        logic [PORTS-1:0]             sel;
        logic [PORTS-1:0][ADDR_W-1:0] addr;
    } arb_st_t;

    arb_st_t st_d, st_q;
    logic    clash;
    logic    l_held, r_held, r_wins;
    logic [PORTS-1:0] blocked;

    always_comb begin
        st_d.sel  = sel;
        st_d.addr = addr;

        clash  = sel[PORT_L] && sel[PORT_R] && (addr[PORT_L] == addr[PORT_R])
                 && (wr_req[PORT_L] || wr_req[PORT_R]);
        l_held = st_q.sel[PORT_L] && (st_q.addr[PORT_L] == addr[PORT_L]);
        r_held = st_q.sel[PORT_R] && (st_q.addr[PORT_R] == addr[PORT_R]);
        r_wins = r_held && !l_held;

        busy_out_n = '1;
        if (ms_sel && clash) begin
            if (r_wins) busy_out_n[PORT_L] = 1'b0;
            else        busy_out_n[PORT_R] = 1'b0;
        end

        blocked = ms_sel ? ~busy_out_n : ~busy_in_n;
        wr_ok   = wr_req & ~blocked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dpram_array.sv
module dpram_array
    import dpram_arb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                                 clk,
    input  logic [PORTS-1:0]                     wr_ok,
    input  logic [PORTS-1:0][LANES-1:0]          lanes,
    input  logic [PORTS-1:0][ADDR_W-1:0]         addr,
    input  logic [PORTS-1:0][LANES*LANE_W-1:0]   wdata,
    output logic [PORTS-1:0][LANES*LANE_W-1:0]   rd_word
);
    localparam int DATA_W = LANES * LANE_W;
    localparam int DEPTH  = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_comb begin
        for (int p = 0; p < PORTS; p++) rd_word[p] = mem[addr[p]];
    end

    // Higher port index applied first so that the left port lands last.
    always_ff @(posedge clk) begin
        for (int p = PORTS - 1; p >= 0; p--) begin
            for (int k = 0; k < LANES; k++) begin
                if (wr_ok[p] && lanes[p][k])
                    mem[addr[p]][k*LANE_W +: LANE_W] <= wdata[p][k*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/dpram_arb.sv
module dpram_arb
    import dpram_arb_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ms_sel,
    input  logic [ADDR_W-1:0]        l_addr,
    input  logic [2*LANE_W-1:0]      l_wdata,
    output logic [2*LANE_W-1:0]      l_rdata,
    input  logic                     l_wr,
    input  logic                     l_oe,
    input  logic                     l_ce0_n,
    input  logic                     l_ce1,
    input  logic                     l_ub,
    input  logic                     l_lb,
    input  logic                     l_busy_n_i,
    output logic                     l_busy_n_o,
    input  logic [ADDR_W-1:0]        r_addr,
    input  logic [2*LANE_W-1:0]      r_wdata,
    output logic [2*LANE_W-1:0]      r_rdata,
    input  logic                     r_wr,
    input  logic                     r_oe,
    input  logic                     r_ce0_n,
    input  logic                     r_ce1,
    input  logic                     r_ub,
    input  logic                     r_lb,
    input  logic                     r_busy_n_i,
    output logic                     r_busy_n_o
);
    localparam int DATA_W = LANES * LANE_W;

    typedef struct packed {
        logic [PORTS-1:0][DATA_W-1:0] rdata;
    } top_st_t;

    top_st_t st_d, st_q;

    logic [PORTS-1:0]             ce0_n_v, ce1_v, wr_v, oe_v, ub_v, lb_v;
    logic [PORTS-1:0]             sel_v, wr_req_v, rd_drive_v, wr_ok_v;
    logic [PORTS-1:0]             busy_in_v, busy_out_v;
    logic [PORTS-1:0][LANES-1:0]  lanes_v;
    logic [PORTS-1:0][ADDR_W-1:0] addr_v;
    logic [PORTS-1:0][DATA_W-1:0] wdata_v, rd_word_v;

    assign ce0_n_v   = {r_ce0_n, l_ce0_n};
    assign ce1_v     = {r_ce1, l_ce1};
    assign wr_v      = {r_wr, l_wr};
    assign oe_v      = {r_oe, l_oe};
    assign ub_v      = {r_ub, l_ub};
    assign lb_v      = {r_lb, l_lb};
    assign busy_in_v = {r_busy_n_i, l_busy_n_i};
    assign addr_v    = {r_addr, l_addr};
    assign wdata_v   = {r_wdata, l_wdata};

    for (genvar p = 0; p < PORTS; p++) begin : g_port
        dpram_port_dec dec_i (
            .ce0_n    (ce0_n_v[p]),
            .ce1      (ce1_v[p]),
            .wr       (wr_v[p]),
            .oe       (oe_v[p]),
            .ub       (ub_v[p]),
            .lb       (lb_v[p]),
            .sel      (sel_v[p]),
            .wr_req   (wr_req_v[p]),
            .rd_drive (rd_drive_v[p]),
            .lanes    (lanes_v[p])
        );
    end

    dpram_arbiter #(.ADDR_W(ADDR_W)) arb_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .ms_sel     (ms_sel),
        .sel        (sel_v),
        .wr_req     (wr_req_v),
        .addr       (addr_v),
        .busy_in_n  (busy_in_v),
        .busy_out_n (busy_out_v),
        .wr_ok      (wr_ok_v)
    );

    dpram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) mem_i (
        .clk     (clk),
        .wr_ok   (wr_ok_v),
        .lanes   (lanes_v),
        .addr    (addr_v),
        .wdata   (wdata_v),
        .rd_word (rd_word_v)
    );

    always_comb begin
        st_d = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (rd_drive_v[p]) begin
                for (int k = 0; k < LANES; k++) begin
                    if (lanes_v[p][k])
                        st_d.rdata[p][k*LANE_W +: LANE_W] = rd_word_v[p][k*LANE_W +: LANE_W];
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign l_rdata    = st_q.rdata[PORT_L];
    assign r_rdata    = st_q.rdata[PORT_R];
    assign l_busy_n_o = busy_out_v[PORT_L];
    assign r_busy_n_o = busy_out_v[PORT_R];
endmodule

// File: rtl/dpram_arb_chk.sv
module dpram_arb_chk #(
    parameter int ADDR_W = 10,
    parameter int LANE_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                ms_sel,
    input logic [ADDR_W-1:0]   l_addr,
    input logic [2*LANE_W-1:0] l_rdata,
    input logic                l_wr,
    input logic                l_oe,
    input logic                l_ce0_n,
    input logic                l_ce1,
    input logic                l_busy_n_o,
    input logic [ADDR_W-1:0]   r_addr,
    input logic [2*LANE_W-1:0] r_rdata,
    input logic                r_wr,
    input logic                r_oe,
    input logic                r_ce0_n,
    input logic                r_ce1,
    input logic                r_busy_n_o
);
    logic l_on, r_on, hit;
    assign l_on = !l_ce0_n && l_ce1;
    assign r_on = !r_ce0_n && r_ce1;
    assign hit  = l_on && r_on && (l_addr == r_addr) && (l_wr || r_wr);

    AST_ONE_LOSER: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({~l_busy_n_o, ~r_busy_n_o}) <= 1); // R8
    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        (!l_busy_n_o || !r_busy_n_o) |-> hit); // R8
    AST_CLASH_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
        (ms_sel && hit) |-> ($countones({~l_busy_n_o, ~r_busy_n_o}) == 1)); // R8
    AST_SLAVE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_sel |-> (l_busy_n_o && r_busy_n_o)); // R11
    AST_L_NO_OE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !l_oe |=> (l_rdata == '0)); // R6
    AST_R_NO_OE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !r_oe |=> (r_rdata == '0)); // R6
    AST_L_DESEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !l_on |=> (l_rdata == '0)); // R5
    AST_R_DESEL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !r_on |=> (r_rdata == '0)); // R5
endmodule

bind dpram_arb dpram_arb_chk #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) chk_i (.*);

// File: tb/dpram_arb_tb_top.sv
module dpram_arb_tb_top;
    localparam int AW    = 6;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_sel = 1'b1;
    logic [AW-1:0] l_addr = '0, r_addr = '0;
    logic [15:0]   l_wdata = '0, r_wdata = '0, l_rdata, r_rdata;
    logic l_wr = 0, l_oe = 0, l_ce0_n = 1, l_ce1 = 0, l_ub = 0, l_lb = 0, l_busy_n_i = 1, l_busy_n_o;
    logic r_wr = 0, r_oe = 0, r_ce0_n = 1, r_ce1 = 0, r_ub = 0, r_lb = 0, r_busy_n_i = 1, r_busy_n_o;

    int checks = 0;
    int failures = 0;
    bit done = 0;
    logic [15:0] model [DEPTH];

    always #5 clk = ~clk;

    dpram_arb #(.ADDR_W(AW), .LANE_W(8)) dut_i (.*);

    function automatic logic [15:0] lmask(input logic ub, input logic lb);
        return {ub ? 8'hFF : 8'h00, lb ? 8'hFF : 8'h00};
    endfunction

    function automatic logic [15:0] pat(input int a, input int salt);
        return 16'((a * 16'h0931) ^ (salt * 16'h1F07) ^ 16'hC3A5);
    endfunction

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic idle();
        l_wr = 0; l_oe = 0; l_ce0_n = 1; l_ce1 = 0; l_ub = 0; l_lb = 0;
        r_wr = 0; r_oe = 0; r_ce0_n = 1; r_ce1 = 0; r_ub = 0; r_lb = 0;
    endtask

    task automatic set_l(input logic wr, input logic oe, input logic ub, input logic lb,
                         input int a, input logic [15:0] d);
        l_ce0_n = 0; l_ce1 = 1; l_wr = wr; l_oe = oe; l_ub = ub; l_lb = lb;
        l_addr = AW'(a); l_wdata = d;
    endtask

    task automatic set_r(input logic wr, input logic oe, input logic ub, input logic lb,
                         input int a, input logic [15:0] d);
        r_ce0_n = 0; r_ce1 = 1; r_wr = wr; r_oe = oe; r_ub = ub; r_lb = lb;
        r_addr = AW'(a); r_wdata = d;
    endtask

    // Busy is combinational: checked before the edge; read data checked after it.
    task automatic go(input logic eb_l, input logic eb_r, input string tag);
        #1;
        chk({tag, " left busy"}, {15'd0, l_busy_n_o}, {15'd0, eb_l});
        chk({tag, " right busy"}, {15'd0, r_busy_n_o}, {15'd0, eb_r});
        @(posedge clk); #2;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [15:0] nv, old;
        idle();
        repeat (3) @(posedge clk);
        // R1: reset values
        chk("R1 left rdata", l_rdata, 16'h0);
        chk("R1 right rdata", r_rdata, 16'h0);
        chk("R1 busy", {14'd0, l_busy_n_o, r_busy_n_o}, 16'h3);
        #2 rst_n = 1;
        @(posedge clk); #2;
        chk("R1 rdata after release", l_rdata | r_rdata, 16'h0);

        // R2: full-word fill on left, read back on right (other port)
        for (int a = 0; a < DEPTH; a++) begin
            idle(); set_l(1, 0, 1, 1, a, pat(a, 1)); model[a] = pat(a, 1);
            go(1, 1, "R2 fill");
        end
        // R7: both ports read the same word together
        for (int a = 0; a < DEPTH; a++) begin
            idle(); set_l(0, 1, 1, 1, a, 16'h0); set_r(0, 1, 1, 1, a, 16'h0);
            go(1, 1, "R7 shared read");
            chk("R2 R7 right read", r_rdata, model[a]);
            chk("R7 left read", l_rdata, model[a]);
        end

        // R3 / R4: lane-masked writes via right, shifted-mask reads via left
        for (int a = 0; a < DEPTH; a++) begin
            logic wu, wl, qu, ql;
            wu = a[1]; wl = a[0]; qu = a[2]; ql = ~a[0];
            idle(); set_r(1, 0, wu, wl, a, pat(a, 2));
            model[a] = (model[a] & ~lmask(wu, wl)) | (pat(a, 2) & lmask(wu, wl));
            go(1, 1, "R3 lane write");
            idle(); set_l(0, 1, qu, ql, a, 16'h0);
            go(1, 1, "R4 lane read");
            chk("R3 R4 masked read", l_rdata, model[a] & lmask(qu, ql));
        end

        // R5: deselected combinations write nothing and read zero
        for (int c = 0; c < 3; c++) begin
            idle(); set_l(1, 1, 1, 1, 40, 16'hDEAD);
            l_ce0_n = (c != 1); l_ce1 = (c == 1) ? 1'b0 : (c == 2);
            if (c == 2) l_ce0_n = 1;
            go(1, 1, "R5 bad select write");
            idle(); set_l(0, 1, 1, 1, 40, 16'h0);
            l_ce0_n = (c == 0); l_ce1 = (c != 0) ? 1'b0 : 1'b0;
            go(1, 1, "R5 bad select read");
            chk("R5 deselected rdata", l_rdata, 16'h0);
            idle(); set_r(0, 1, 1, 1, 40, 16'h0);
            go(1, 1, "R5 readback");
            chk("R5 word untouched", r_rdata, model[40]);
        end

        // R6: output enable low gives zero
        idle(); set_r(0, 0, 1, 1, 12, 16'h0);
        go(1, 1, "R6");
        chk("R6 oe low rdata", r_rdata, 16'h0);

        // R9 + R2: left write vs right read, new on both sides; right sees old word
        idle(); go(1, 1, "gap");
        nv = 16'hA51E; old = model[3];
        set_l(1, 0, 1, 1, 3, nv); set_r(0, 1, 1, 1, 3, 16'h0);
        go(1, 0, "R9 write vs read");
        chk("R2 read-before-write", r_rdata, old);
        model[3] = nv;
        idle(); set_r(0, 1, 1, 1, 3, 16'h0);
        go(1, 1, "R2 readback");
        chk("R2 new value", r_rdata, nv);

        // R9: both new writers to one word, left wins
        idle(); go(1, 1, "gap");
        set_l(1, 0, 1, 1, 7, 16'h1111); set_r(1, 0, 1, 1, 7, 16'h2222);
        go(1, 0, "R9 double write");
        model[7] = 16'h1111;
        idle(); set_l(0, 1, 1, 1, 7, 16'h0);
        go(1, 1, "R9 readback");
        chk("R9 left kept", l_rdata, model[7]);

        // R10: right already held word 9, so it keeps priority
        idle(); go(1, 1, "gap");
        set_r(0, 1, 1, 1, 9, 16'h0);
        go(1, 1, "R10 hold");
        set_r(0, 1, 1, 1, 9, 16'h0); set_l(1, 0, 1, 1, 9, 16'hBEEF);
        go(0, 1, "R10 right holds");
        chk("R10 holder read", r_rdata, model[9]);
        idle(); set_l(0, 1, 1, 1, 9, 16'h0);
        go(1, 1, "R10 readback");
        chk("R10 left write dropped", l_rdata, model[9]);

        // R10: both held word 11, left wins, right write dropped
        idle(); go(1, 1, "gap");
        set_l(0, 1, 1, 1, 11, 16'h0); set_r(0, 1, 1, 1, 11, 16'h0);
        go(1, 1, "R10 both hold");
        set_l(0, 1, 1, 1, 11, 16'h0); set_r(1, 0, 1, 1, 11, 16'hCAFE);
        go(1, 0, "R10 both held");
        chk("R10 left read", l_rdata, model[11]);
        idle(); set_r(0, 1, 1, 1, 11, 16'h0);
        go(1, 1, "R10 readback2");
        chk("R10 right write dropped", r_rdata, model[11]);

        // R8: writes to different words raise no busy
        idle(); set_l(1, 0, 1, 1, 20, 16'h0A0A); set_r(1, 0, 1, 1, 21, 16'h0B0B);
        go(1, 1, "R8 distinct writes");
        model[20] = 16'h0A0A; model[21] = 16'h0B0B;
        idle(); set_l(0, 1, 1, 1, 21, 16'h0); set_r(0, 1, 1, 1, 20, 16'h0);
        go(1, 1, "R8 readback");
        chk("R8 word 21", l_rdata, model[21]);
        chk("R8 word 20", r_rdata, model[20]);

        // R11: slave mode, left blocked by its busy input
        ms_sel = 0; l_busy_n_i = 0;
        idle(); set_l(1, 0, 1, 1, 30, 16'h3333); set_r(1, 0, 1, 1, 30, 16'h4444);
        go(1, 1, "R11 slave clash");
        model[30] = 16'h4444;
        idle(); set_l(0, 1, 1, 1, 30, 16'h0);
        go(1, 1, "R11 readback");
        chk("R11 blocked left", l_rdata, model[30]);

        // R12: slave mode, both write one word, left lane dominates
        l_busy_n_i = 1;
        idle(); set_l(1, 0, 0, 1, 31, 16'h5566); set_r(1, 0, 1, 1, 31, 16'h7788);
        go(1, 1, "R12 slave merge");
        model[31] = 16'h7766;
        idle(); set_l(1, 0, 1, 1, 32, 16'h1234); set_r(1, 0, 1, 1, 32, 16'h9876);
        go(1, 1, "R12 slave overlap");
        model[32] = 16'h1234;
        idle(); set_r(0, 1, 1, 1, 31, 16'h0); set_l(0, 1, 1, 1, 32, 16'h0);
        go(1, 1, "R12 readback");
        chk("R12 merged lanes", r_rdata, model[31]);
        chk("R12 left overlap wins", l_rdata, model[32]);
        ms_sel = 1;

        idle(); go(1, 1, "end");
        finish_run();
    end
endmodule